// File: doc/BRIEF.md
# Serial Register Access Command Engine

This block sits between an asynchronous serial line and an on-chip register map. It decodes short command frames from a host and turns each one into a single byte-wide access to a 16-bit-addressed register space. A frame starts with a command byte. The address follows, low byte first and high byte second. A write frame then carries one data byte. The engine answers with a status byte. After a successful read it also sends the byte that was read.

Accesses leave through a request/grant bus port. The port shares the register file with internal fault and state-monitor writers, which take precedence. The engine therefore holds its request steady until an arbiter grants it. If the host stalls in the middle of a frame for longer than a set number of clock cycles, the partial frame is dropped and the engine waits for a new command.

Top module: `uart_reg_access`

## Requirements
- R1: Serial frames in both directions are one low start bit, eight data bits sent least significant first, and one high stop bit, each bit lasting CLKS_PER_BIT clock cycles. The transmit line idles high.
- R2: After reset the engine waits for a command byte. The transmit line is high and no bus request is raised.
- R3: Command 00h with an implemented address starts one bus read. The engine replies with status 00h and then the byte read.
- R4: Command 01h with an implemented address takes one further data byte and starts one bus write carrying that address and data. The engine replies with status 00h only.
- R5: Commands 02h to FFh are reserved. After the two address bytes the engine replies with status 01h only and makes no bus access.
- R6: An address at or above MAP_DEPTH gets status 01h with no bus access. A read sends no data byte. A write still consumes its data byte before the reply.
- R7: A bus request stays asserted, with address, write enable and write data unchanged, for however many cycles the grant is withheld. Each grant ends the access.
- R8: If more than TIMEOUT_CYC cycles pass between received bytes of one frame, the partial frame is discarded and the next byte is decoded as a command. Shorter gaps do not disturb the frame.
- R9: A received byte whose stop bit samples low is discarded and does not advance the parser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial data from host |
| tx_o | output | 1 | Serial data to host |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 16 | Register address |
| bus_wdata_o | output | 8 | Write data |
| bus_gnt_i | input | 1 | Grant; the access completes in the cycle where request and grant are both high |
| bus_rdata_i | input | 8 | Read data, valid in the grant cycle |

## Verification
The hardest case to reach from the ports is the timeout boundary. The parser must discard a partial frame after a long gap and keep it after a shorter one. The stimulus creates both cases by stopping mid-frame on purpose. It then sends a frame whose bytes would decode as a different access if the stale bytes had been kept, so a wrong timeout shows up as a wrong reply or a wrong access count. The bench also withholds the grant for random stretches to exercise the request-hold rule, and it sends a byte with a low stop bit to check that such bytes are dropped.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam logic [7:0] CMD_RD = 8'h00;
  localparam logic [7:0] CMD_WR = 8'h01;
  localparam logic [7:0] ST_OK  = 8'h00;
  localparam logic [7:0] ST_ERR = 8'h01;

  typedef enum logic [3:0] {
    P_CMD, P_ALO, P_AHI, P_WDAT, P_BUS, P_ERR, P_ERR_W, P_DAT, P_DAT_W
  } pstate_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD
  } rxstate_e;
endpackage

// File: rtl/uart_rx_unit.sv
module uart_rx_unit import uart_reg_pkg::*; #(
  parameter int unsigned CLKS_PER_BIT = 868
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  localparam int unsigned CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] FULL = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

  logic [1:0]    sync_q;
  logic          rxs;
  rxstate_e      st_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    idx_q;
  logic [7:0]    sh_q;

  assign rxs = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      sync_q  <= {sync_q[0], rx_i};
      valid_o <= 1'b0;
      case (st_q)
        RX_IDLE: if (!rxs) begin st_q <= RX_START; cnt_q <= '0; end
        RX_START: begin
          if (cnt_q == HALF) begin
            cnt_q <= '0;
            idx_q <= '0;
            st_q  <= rxs ? RX_IDLE : RX_DATA;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_DATA: begin
          if (cnt_q == FULL) begin
            cnt_q <= '0;
            sh_q  <= {rxs, sh_q[7:1]};
            if (idx_q == 3'd7) st_q <= RX_STOP;
            idx_q <= idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_STOP: begin
          if (cnt_q == FULL) begin
            cnt_q <= '0;
            if (rxs) begin
              valid_o <= 1'b1;
              data_o  <= sh_q;
              st_q    <= RX_IDLE;
            end else st_q <= RX_HOLD;  // framing error: wait for line high
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_HOLD: if (rxs) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  AST_RX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R9
endmodule

// File: rtl/uart_tx_unit.sv
module uart_tx_unit #(
  parameter int unsigned CLKS_PER_BIT = 868
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       tx_o
);
  localparam int unsigned CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] FULL = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;
  logic [3:0]    n_q;
  logic [9:0]    sh_q;

  assign tx_o = busy_o ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
      n_q    <= '0;
      sh_q   <= '1;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        sh_q   <= {1'b1, data_i, 1'b0};
        cnt_q  <= '0;
        n_q    <= '0;
      end
    end else if (cnt_q == FULL) begin
      cnt_q <= '0;
      sh_q  <= {1'b1, sh_q[9:1]};
      if (n_q == 4'd9) busy_o <= 1'b0;
      else n_q <= n_q + 1'b1;
    end else cnt_q <= cnt_q + 1'b1;
  end

  AST_TX_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R1
endmodule

// File: rtl/cmd_parser.sv
module cmd_parser import uart_reg_pkg::*; #(
  parameter int unsigned MAP_DEPTH   = 256,
  parameter int unsigned TIMEOUT_CYC = 5000000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        tx_busy_i,
  output logic        tx_start_o,
  output logic [7:0]  tx_data_o,
  output logic        bus_req_o,
  output logic        bus_we_o,
  output logic [15:0] bus_addr_o,
  output logic [7:0]  bus_wdata_o,
  input  logic        bus_gnt_i,
  input  logic [7:0]  bus_rdata_i
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT_CYC - 1);

  pstate_e       st_q;
  logic [7:0]    cmd_q, rdata_q;
  logic          err_q;
  logic [TW-1:0] to_q;
  logic          waiting, expire, hi_ok, cur_ok;

  assign waiting     = (st_q == P_ALO) || (st_q == P_AHI) || (st_q == P_WDAT);
  assign expire      = waiting && !rx_valid_i && (to_q == TO_LAST);
  assign hi_ok       = 32'({rx_data_i, bus_addr_o[7:0]}) < MAP_DEPTH;
  assign cur_ok      = 32'(bus_addr_o) < MAP_DEPTH;
  assign bus_req_o   = (st_q == P_BUS);
  assign bus_we_o    = (cmd_q == CMD_WR);
  assign tx_start_o  = (st_q == P_ERR) || (st_q == P_DAT);
  assign tx_data_o   = (st_q == P_ERR) ? (err_q ? ST_ERR : ST_OK) : rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) to_q <= '0;
    else if (!waiting || rx_valid_i) to_q <= '0;
    else to_q <= to_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= P_CMD;
      cmd_q       <= '0;
      rdata_q     <= '0;
      err_q       <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
    end else if (expire) begin
      st_q <= P_CMD;
    end else begin
      case (st_q)
        P_CMD: if (rx_valid_i) begin
          cmd_q <= rx_data_i;
          err_q <= 1'b0;
          st_q  <= P_ALO;
        end
        P_ALO: if (rx_valid_i) begin
          bus_addr_o[7:0] <= rx_data_i;
          st_q            <= P_AHI;
        end
        P_AHI: if (rx_valid_i) begin
          bus_addr_o[15:8] <= rx_data_i;
          if (cmd_q == CMD_WR) st_q <= P_WDAT;
          else if (cmd_q == CMD_RD && hi_ok) st_q <= P_BUS;
          else begin err_q <= 1'b1; st_q <= P_ERR; end
        end
        P_WDAT: if (rx_valid_i) begin
          bus_wdata_o <= rx_data_i;
          if (cur_ok) st_q <= P_BUS;
          else begin err_q <= 1'b1; st_q <= P_ERR; end
        end
        P_BUS: if (bus_gnt_i) begin
          rdata_q <= bus_rdata_i;
          st_q    <= P_ERR;
        end
        P_ERR:   st_q <= P_ERR_W;
        P_ERR_W: if (!tx_busy_i) st_q <= (cmd_q == CMD_RD && !err_q) ? P_DAT : P_CMD;
        P_DAT:   st_q <= P_DAT_W;
        P_DAT_W: if (!tx_busy_i) st_q <= P_CMD;
        default: st_q <= P_CMD;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o)
      && $stable(bus_we_o) && $stable(bus_wdata_o)); // R7
  AST_REQ_IN_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> 32'(bus_addr_o) < MAP_DEPTH); // R6
  AST_NO_TX_ON_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !tx_busy_i); // R3
  AST_TIMEOUT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> st_q == P_CMD && !bus_req_o); // R8
endmodule

// File: rtl/uart_reg_access.sv
module uart_reg_access #(
  parameter int unsigned CLKS_PER_BIT = 868,
  parameter int unsigned MAP_DEPTH    = 256,
  parameter int unsigned TIMEOUT_CYC  = 5000000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_i,
  output logic        tx_o,
  output logic        bus_req_o,
  output logic        bus_we_o,
  output logic [15:0] bus_addr_o,
  output logic [7:0]  bus_wdata_o,
  input  logic        bus_gnt_i,
  input  logic [7:0]  bus_rdata_i
);
  logic       rx_valid, tx_start, tx_busy;
  logic [7:0] rx_data, tx_data;

  uart_rx_unit #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk_i, .rst_ni, .rx_i, .valid_o(rx_valid), .data_o(rx_data)
  );

  uart_tx_unit #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk_i, .rst_ni, .start_i(tx_start), .data_i(tx_data),
    .busy_o(tx_busy), .tx_o
  );

  cmd_parser #(.MAP_DEPTH(MAP_DEPTH), .TIMEOUT_CYC(TIMEOUT_CYC)) u_parser (
    .clk_i, .rst_ni,
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_busy_i(tx_busy), .tx_start_o(tx_start), .tx_data_o(tx_data),
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o,
    .bus_gnt_i, .bus_rdata_i
  );
endmodule

// File: tb/uart_reg_access_test.sv
module uart_reg_access_test;
  localparam int CPB = 16;
  localparam int MAP = 256;
  localparam int TO  = 3000;

  logic clk = 0, rst_n = 0, rx_i = 1;
  logic tx_o, bus_req_o, bus_we_o, bus_gnt_i = 0;
  logic [15:0] bus_addr_o;
  logic [7:0]  bus_wdata_o, bus_rdata_i;

  logic [7:0] mem [MAP];
  logic [7:0] ref_mem [MAP];
  logic [7:0] rxq [$];
  logic [7:0] mb;
  int errors = 0, checks = 0, acc_cnt = 0, wcnt = 0, stall_viol = 0, max_wait = 0, cur_wait = 0;
  logic prev_wait = 0;
  logic [15:0] prev_addr;
  logic [15:0] last_addr;
  logic [7:0]  last_data;
  logic        last_we;

  always #5 clk = ~clk;

  uart_reg_access #(.CLKS_PER_BIT(CPB), .MAP_DEPTH(MAP), .TIMEOUT_CYC(TO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i, .tx_o, .bus_req_o, .bus_we_o,
    .bus_addr_o, .bus_wdata_o, .bus_gnt_i, .bus_rdata_i
  );

  assign bus_rdata_i = mem[bus_addr_o[7:0]];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus responder with random grant delay
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req_o && prev_wait && (bus_addr_o != prev_addr)) stall_viol++;
      if (bus_req_o && !bus_gnt_i) begin
        if (wcnt == 0) begin
          bus_gnt_i = 1;
          acc_cnt++;
          last_addr = bus_addr_o; last_data = bus_wdata_o; last_we = bus_we_o;
          if (bus_we_o) mem[bus_addr_o[7:0]] = bus_wdata_o;
          if (cur_wait > max_wait) max_wait = cur_wait;
          cur_wait = 0;
          wcnt = $urandom_range(0, 12);
        end else begin
          wcnt--;
          cur_wait++;
        end
      end else bus_gnt_i = 0;
      prev_wait = bus_req_o && !bus_gnt_i;
      prev_addr = bus_addr_o;
    end
  end

  // serial receive monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx_o === 1'b0) begin
        repeat (CPB / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          mb[i] = tx_o;
        end
        repeat (CPB) @(negedge clk);
        rxq.push_back(mb);
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, input bit stop_ok);
    rx_i = 0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx_i = stop_ok;
    repeat (CPB) @(negedge clk);
    rx_i = 1;
    if (!stop_ok) repeat (2 * CPB) @(negedge clk);
  endtask

  task automatic do_txn(input logic [7:0] cmd, input logic [15:0] addr,
                        input logic [7:0] wd, input int gap);
    bit inr, ok;
    int acc0;
    inr = addr < MAP;
    ok  = inr && (cmd <= 8'h01);
    rxq.delete();
    acc0 = acc_cnt;
    send_byte(cmd, 1);       repeat (gap) @(negedge clk);
    send_byte(addr[7:0], 1); repeat (gap) @(negedge clk);
    send_byte(addr[15:8], 1);
    if (cmd == 8'h01) begin
      repeat (gap) @(negedge clk);
      send_byte(wd, 1);
    end
    repeat (600) @(negedge clk);
    if (cmd == 8'h00 && ok) begin
      chk(rxq.size() == 2, "R3 reply count", rxq.size(), 2);
      if (rxq.size() == 2) begin
        chk(rxq[0] == 8'h00, "R3 status", rxq[0], 0);
        chk(rxq[1] == ref_mem[addr[7:0]], "R3 data", rxq[1], ref_mem[addr[7:0]]);
      end
      chk(acc_cnt - acc0 == 1, "R3 access count", acc_cnt - acc0, 1);
    end else if (cmd == 8'h01 && ok) begin
      ref_mem[addr[7:0]] = wd;
      chk(rxq.size() == 1 && rxq[0] == 8'h00, "R4 status", rxq.size() > 0 ? rxq[0] : 8'hEE, 0);
      chk(acc_cnt - acc0 == 1 && last_we && last_addr == addr && last_data == wd,
          "R4 bus write", {last_addr, last_data}, {addr, wd});
    end else begin
      chk(rxq.size() == 1 && rxq[0] == 8'h01, cmd > 8'h01 ? "R5 status" : "R6 status",
          rxq.size() > 0 ? rxq[0] : 8'hEE, 1);
      chk(acc_cnt - acc0 == 0, cmd > 8'h01 ? "R5 no access" : "R6 no access", acc_cnt - acc0, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < MAP; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (5) @(negedge clk);
    chk(tx_o === 1'b1, "R2 tx idle", tx_o, 1);
    chk(bus_req_o === 1'b0, "R2 no request", bus_req_o, 0);
    rst_n = 1;
    repeat (200) @(negedge clk);
    chk(rxq.size() == 0 && !bus_req_o, "R2 quiet after reset", rxq.size(), 0);

    // directed: R1 framing via read/write round trips
    do_txn(8'h00, 16'h0005, 8'h00, 0);
    do_txn(8'h01, 16'h00A5, 8'h3C, 0);
    do_txn(8'h00, 16'h00A5, 8'h00, 0);
    chk(rxq.size() == 2 && rxq[1] == 8'h3C, "R1 byte order", rxq.size() > 1 ? rxq[1] : 8'hEE, 8'h3C);
    do_txn(8'h01, 16'h00FF, 8'h81, 0);
    do_txn(8'h00, 16'h00FF, 8'h00, 0);
    do_txn(8'h02, 16'h0010, 8'h00, 0);
    do_txn(8'hFF, 16'h0010, 8'h00, 0);
    do_txn(8'h00, 16'h0100, 8'h00, 0);
    do_txn(8'h01, 16'hFF00, 8'h55, 0);
    do_txn(8'h00, 16'h0000, 8'h00, 0);

    // R8: abandoned frame, then a fresh frame
    rxq.delete();
    send_byte(8'h01, 1);
    send_byte(8'h20, 1);
    repeat (TO + 200) @(negedge clk);
    chk(rxq.size() == 0, "R8 no reply on abandon", rxq.size(), 0);
    do_txn(8'h01, 16'h0021, 8'h9A, 0);
    do_txn(8'h00, 16'h0020, 8'h00, 0);
    // R8: gaps below the limit keep the frame
    do_txn(8'h01, 16'h0030, 8'h77, TO / 2);
    do_txn(8'h00, 16'h0030, 8'h00, TO / 2);

    // R9: byte with low stop bit is dropped
    send_byte(8'h00, 0);
    do_txn(8'h01, 16'h0040, 8'h12, 0);
    do_txn(8'h00, 16'h0040, 8'h00, 0);

    // constrained random
    for (int n = 0; n < 45; n++) begin
      logic [7:0] c;
      logic [15:0] a;
      int r;
      r = $urandom_range(0, 9);
      c = (r < 4) ? 8'h00 : (r < 8) ? 8'h01 : 8'($urandom_range(2, 255));
      a = ($urandom_range(0, 7) == 0) ? 16'($urandom_range(256, 65535)) : 16'($urandom_range(0, 255));
      do_txn(c, a, 8'($urandom), $urandom_range(0, 1) ? 0 : $urandom_range(0, 50));
    end

    chk(stall_viol == 0, "R7 request held", stall_viol, 0);
    chk(max_wait > 0, "R7 stall exercised", max_wait, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule